// File: doc/BRIEF.md
# Reset Controller with Source Flags

This block sits beside the system registers of a small controller chip. It turns software requests into one-shot reset pulses: one for the whole chip and one that hits only the processor core and its flash controller. It also keeps a set of sticky flags that show which source caused a reset. The sources are the power-on reset, the external reset pin, the watchdog, the brown-out detector, a system-reset request from the core and a core lockup. Software reads the flags and clears each one by writing 1 to it.

A second register drives level-type reset lines for individual peripherals. Each line stays asserted while its bit is 1. The two one-shot request bits accept writes only while the register protection is open. The power-on reset input is asynchronous and active low. The other five hardware sources pass through a two-flop synchroniser before they are used.

Top module: `rstc_top`

## Requirements
- R1: While `porN` is low and after it rises, the status reads 0x001 (only the power-on flag set), the one-shot and peripheral registers read 0, and `chipRstOut` and `coreRstOut` are low.
- R2: A hardware source held high sets its status bit: pin bit 1, watchdog bit 2, brown-out bit 4, core system request bit 5, lockup bit 8. `chipRstOut` is high from two clock edges after the source is first sampled high, and the flag is set one edge later. The flag stays set after the source drops.
- R3: A write to address 0 clears every status flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: If a flag's source is active in the same cycle that software writes 1 to clear that flag, the flag stays set.
- R5: With protection open, writing 1 to bit 0 at address 1 raises one-shot bit 0 for exactly two cycles. During those cycles both `chipRstOut` and `coreRstOut` are high, and status bit 0 becomes set.
- R6: With protection open, writing 1 to bit 1 at address 1 raises one-shot bit 1 for exactly two cycles. During that time `coreRstOut` is high, `chipRstOut` stays low, and status bit 7 becomes set.
- R7: While `protOpen` is low, writes to address 1 change nothing: the one-shot bits and both reset outputs stay low.
- R8: Address 2 holds the peripheral reset bits 1, 2, 3, 8, 9, 12, 16, 17, 20, 22 and 28 (mask 0x1053130E). These bits can be written whatever the protection state, and every other bit reads 0. Address 3 is ignored.
- R9: Writing 1 to a one-shot bit that is already active does not make its pulse longer.
- R10: Only `porN` clears the status flags. A one-shot chip or core reset leaves flags that are already set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| pinRstIn | input | 1 | External reset pin request, active high |
| wdtRstIn | input | 1 | Watchdog reset request |
| bodRstIn | input | 1 | Brown-out reset request |
| sysReqIn | input | 1 | Core system-reset request |
| lockupIn | input | 1 | Core lockup indication |
| protOpen | input | 1 | High while register protection is disabled |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 status, 1 one-shot, 2 peripheral, 3 unused |
| wrData | input | 32 | Write data |
| chipRstOut | output | 1 | Whole-chip reset |
| coreRstOut | output | 1 | Core and flash controller reset |
| periphRstOut | output | 32 | Peripheral reset lines and register readback |
| oneShotOut | output | 2 | One-shot bits readback |
| statusOut | output | 32 | Reset-source flags |

## Verification
The checker runs on every cycle. It checks that a synchronised source reaches the chip reset two edges later, that a one-shot pulse lasts exactly two cycles and cannot be stretched, that flags fall only in a cycle that has a status write, that locked writes to the one-shot register do nothing, and that reserved bits stay zero. The bench scenarios are the only place where the source-to-bit mapping, write-1-to-clear against write-0, set-over-clear priority, the core-only pulse leaving the chip reset low, and flags surviving a software reset are shown.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned STS_W   = 9;
  localparam int unsigned REG_W   = 32;
  // status bit for each synchronised source: pin, watchdog, brown-out, sysreq, lockup
  localparam int unsigned SRC_BIT [NUM_SRC] = '{1, 2, 4, 5, 8};
  localparam int unsigned POR_BIT  = 0;
  localparam int unsigned CORE_BIT = 7;
  localparam logic [REG_W-1:0] STS_MASK    = 32'h0000_01B7;
  localparam logic [REG_W-1:0] PERIPH_MASK = 32'h1053_130E;

  localparam logic [1:0] ADDR_STS    = 2'd0;
  localparam logic [1:0] ADDR_SHOT   = 2'd1;
  localparam logic [1:0] ADDR_PERIPH = 2'd2;

  typedef struct packed {
    logic       stsWr;
    logic [1:0] shotLoad;
    logic       periphWr;
  } rstcStrobe_t;
endpackage

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
  import rstc_pkg::*;
(
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [1:0]  shotReq,
  input  logic        protOpen,
  input  logic [1:0]  shotActive,
  output rstcStrobe_t strb
);
  always_comb begin
    strb          = '0;
    strb.stsWr    = wrEn && (wrAddr == ADDR_STS);
    strb.periphWr = wrEn && (wrAddr == ADDR_PERIPH);
    if (wrEn && (wrAddr == ADDR_SHOT) && protOpen)
      strb.shotLoad = shotReq & ~shotActive;
  end
endmodule

// File: rtl/rstc_datapath.sv
module rstc_datapath
  import rstc_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               porN,
  input  logic [NUM_SRC-1:0] srcRaw,
  input  rstcStrobe_t        strb,
  input  logic [REG_W-1:0]   wrData,
  output logic [1:0]         shotActive,
  output logic               chipRst,
  output logic               coreRst,
  output logic [REG_W-1:0]   periphReg,
  output logic [REG_W-1:0]   statusReg
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYCLES - 1);

  logic [NUM_SRC-1:0] srcSync;
  logic [STS_W-1:0]   flags;
  logic [STS_W-1:0]   setVec;
  logic [STS_W-1:0]   clrVec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], srcRaw[g]};
    end
    assign srcSync[g] = chain[SYNC_STAGES-1];
  end

  for (genvar s = 0; s < 2; s++) begin : g_shot
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        shotActive[s] <= 1'b0;
        cnt           <= '0;
      end else if (strb.shotLoad[s]) begin
        shotActive[s] <= 1'b1;
        cnt           <= CNT_LOAD;
      end else if (shotActive[s]) begin
        if (cnt == '0) shotActive[s] <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    setVec = '0;
    for (int i = 0; i < NUM_SRC; i++) setVec[SRC_BIT[i]] = srcSync[i];
    setVec[POR_BIT]  = shotActive[0];
    setVec[CORE_BIT] = shotActive[1];
  end

  assign clrVec = strb.stsWr ? wrData[STS_W-1:0] : '0;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) flags <= STS_W'(1) << POR_BIT;
    else       flags <= ((flags & ~clrVec) | setVec) & STS_MASK[STS_W-1:0];
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              periphReg <= '0;
    else if (strb.periphWr) periphReg <= wrData & PERIPH_MASK;
  end

  assign statusReg = {{(REG_W-STS_W){1'b0}}, flags};
  assign chipRst   = shotActive[0] | (|srcSync);
  assign coreRst   = chipRst | shotActive[1];
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        pinRstIn,
  input  logic        wdtRstIn,
  input  logic        bodRstIn,
  input  logic        sysReqIn,
  input  logic        lockupIn,
  input  logic        protOpen,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  output logic        chipRstOut,
  output logic        coreRstOut,
  output logic [31:0] periphRstOut,
  output logic [1:0]  oneShotOut,
  output logic [31:0] statusOut
);
  rstcStrobe_t strb;
  logic [1:0]  shotActive;

  rstc_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .shotReq   (wrData[1:0]),
    .protOpen  (protOpen),
    .shotActive(shotActive),
    .strb      (strb)
  );

  rstc_datapath #(
    .PULSE_CYCLES(PULSE_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .porN      (porN),
    .srcRaw    ({lockupIn, sysReqIn, bodRstIn, wdtRstIn, pinRstIn}),
    .strb      (strb),
    .wrData    (wrData),
    .shotActive(shotActive),
    .chipRst   (chipRstOut),
    .coreRst   (coreRstOut),
    .periphReg (periphRstOut),
    .statusReg (statusOut)
  );

  assign oneShotOut = shotActive;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
  import rstc_pkg::*;
(
  input logic        clk,
  input logic        porN,
  input logic        pinRstIn,
  input logic        wdtRstIn,
  input logic        bodRstIn,
  input logic        sysReqIn,
  input logic        lockupIn,
  input logic        protOpen,
  input logic        wrEn,
  input logic [1:0]  wrAddr,
  input logic        chipRstOut,
  input logic [31:0] periphRstOut,
  input logic [1:0]  oneShotOut,
  input logic [31:0] statusOut
);
  logic anySrc;
  assign anySrc = pinRstIn | wdtRstIn | bodRstIn | sysReqIn | lockupIn;

  // R2: a sampled source reaches the chip reset after the synchroniser
  a_r2_src_to_chip: assert property (@(posedge clk) disable iff (!porN)
    anySrc |=> ##1 chipRstOut);

  // R5: a one-shot bit never stays high for a third cycle
  a_r5_pulse_max: assert property (@(posedge clk) disable iff (!porN)
    (oneShotOut[0] && $past(oneShotOut[0])) |=> !oneShotOut[0]);
  a_r6_core_pulse_max: assert property (@(posedge clk) disable iff (!porN)
    (oneShotOut[1] && $past(oneShotOut[1])) |=> !oneShotOut[1]);

  // R9: a new pulse lasts at least its second cycle
  a_r9_pulse_min: assert property (@(posedge clk) disable iff (!porN)
    $rose(oneShotOut[0]) |=> oneShotOut[0]);

  // R3 and R10: flags drop only after a status write
  a_r3_flags_fall_on_write: assert property (@(posedge clk) disable iff (!porN)
    !(wrEn && wrAddr == ADDR_STS) |=> ((statusOut & $past(statusOut)) == $past(statusOut)));

  // R7: locked write to the one-shot register does nothing
  a_r7_locked_ignored: assert property (@(posedge clk) disable iff (!porN)
    (wrEn && wrAddr == ADDR_SHOT && !protOpen && oneShotOut == 2'b00) |=> oneShotOut == 2'b00);

  // R8: reserved bits stay zero
  always @(posedge clk) begin
    if (porN) begin
      a_r8_reserved_zero: assert (((periphRstOut & ~PERIPH_MASK) == '0) &&
                                  ((statusOut & ~STS_MASK) == '0));
    end
  end
endmodule

bind rstc_top rstc_checker u_chk (
  .clk         (clk),
  .porN        (porN),
  .pinRstIn    (pinRstIn),
  .wdtRstIn    (wdtRstIn),
  .bodRstIn    (bodRstIn),
  .sysReqIn    (sysReqIn),
  .lockupIn    (lockupIn),
  .protOpen    (protOpen),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .chipRstOut  (chipRstOut),
  .periphRstOut(periphRstOut),
  .oneShotOut  (oneShotOut),
  .statusOut   (statusOut)
);

// File: tb/rstc_top_tb.sv
`timescale 1ns/1ps
module rstc_top_tb;
  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic [4:0]  src = '0;
  logic        protOpen = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        chipRstOut, coreRstOut;
  logic [31:0] periphRstOut, statusOut;
  logic [1:0]  oneShotOut;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  localparam int unsigned SRCBIT [5] = '{1, 2, 4, 5, 8};
  localparam logic [31:0] PMASK = 32'h1053_130E;

  always #2.5 clk = ~clk;

  rstc_top u_dut (
    .clk(clk), .porN(porN),
    .pinRstIn(src[0]), .wdtRstIn(src[1]), .bodRstIn(src[2]),
    .sysReqIn(src[3]), .lockupIn(src[4]),
    .protOpen(protOpen), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chipRstOut(chipRstOut), .coreRstOut(coreRstOut),
    .periphRstOut(periphRstOut), .oneShotOut(oneShotOut), .statusOut(statusOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    #(5.0 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] expSts;
    @(negedge clk);
    check("R1 status in reset", statusOut, 32'h1);
    check("R1 resets low in reset", {chipRstOut, coreRstOut}, 0);
    tick(2);
    porN = 1'b1;
    tick(1);
    check("R1 status", statusOut, 32'h1);
    check("R1 oneshot", oneShotOut, 0);
    check("R1 periph", periphRstOut, 0);
    check("R1 resets", {chipRstOut, coreRstOut}, 0);

    // R2: each hardware source, with R3 clears between
    for (int s = 0; s < 5; s++) begin
      doWrite(2'd0, 32'hFFFF_FFFF);
      check("R3 clear all", statusOut, 0);
      src[s] = 1'b1;
      tick(1);
      check("R2 chip low after one edge", chipRstOut, 0);
      tick(1);
      check("R2 chip reset", {chipRstOut, coreRstOut}, 2'b11);
      check("R2 flag not yet", statusOut, 0);
      tick(1);
      check("R2 flag set", statusOut, 32'h1 << SRCBIT[s]);
      src[s] = 1'b0;
      tick(3);
      check("R2 chip released", chipRstOut, 0);
      check("R2 flag sticky", statusOut, 32'h1 << SRCBIT[s]);
    end

    // R3: write 0 has no effect, write 1 clears only that bit
    src = 5'b11111;
    tick(4);
    src = '0;
    tick(3);
    expSts = 32'h0000_0136;
    check("R3 all set", statusOut, expSts);
    doWrite(2'd0, 32'h0);
    check("R3 write zero", statusOut, expSts);
    for (int s = 0; s < 5; s++) begin
      doWrite(2'd0, 32'h1 << SRCBIT[s]);
      expSts = expSts & ~(32'h1 << SRCBIT[s]);
      check("R3 single clear", statusOut, expSts);
    end

    // R4: set beats clear
    src[1] = 1'b1;
    tick(3);
    doWrite(2'd0, 32'h4);
    check("R4 set wins", statusOut, 32'h4);
    src[1] = 1'b0;
    tick(3);
    doWrite(2'd0, 32'h4);
    check("R4 clear after drop", statusOut, 0);

    // R7: locked
    protOpen = 1'b0;
    doWrite(2'd1, 32'h3);
    check("R7 locked oneshot", oneShotOut, 0);
    check("R7 locked resets", {chipRstOut, coreRstOut}, 0);
    tick(2);
    check("R7 locked status", statusOut, 0);

    // R10: preset pin flag, then chip one-shot (R5)
    src[0] = 1'b1; tick(3); src[0] = 1'b0; tick(3);
    protOpen = 1'b1;
    doWrite(2'd1, 32'h1);
    check("R5 pulse cycle 1", {oneShotOut, chipRstOut, coreRstOut}, 4'b0111);
    tick(1);
    check("R5 pulse cycle 2", {oneShotOut, chipRstOut, coreRstOut}, 4'b0111);
    check("R5 por flag set, R10 pin flag kept", statusOut, 32'h3);
    tick(1);
    check("R5 pulse ended", {oneShotOut, chipRstOut, coreRstOut}, 4'b0000);

    // R6: core one-shot
    doWrite(2'd1, 32'h2);
    check("R6 pulse cycle 1", {oneShotOut, chipRstOut, coreRstOut}, 4'b1001);
    tick(1);
    check("R6 pulse cycle 2", {oneShotOut, chipRstOut, coreRstOut}, 4'b1001);
    check("R6 flag, R10 kept", statusOut, 32'h83);
    tick(1);
    check("R6 pulse ended", {oneShotOut, coreRstOut}, 3'b000);

    // R9: retrigger does not stretch
    doWrite(2'd1, 32'h1);
    doWrite(2'd1, 32'h1);
    check("R9 still active", oneShotOut, 2'b01);
    tick(1);
    check("R9 not extended", oneShotOut, 2'b00);

    // R8: peripheral register sweep, with protection closed
    protOpen = 1'b0;
    for (int b = 0; b < 32; b++) begin
      doWrite(2'd2, 32'h1 << b);
      check("R8 walking bit", periphRstOut, (32'h1 << b) & PMASK);
    end
    doWrite(2'd2, 32'hFFFF_FFFF);
    check("R8 all ones", periphRstOut, PMASK);
    doWrite(2'd3, 32'h0);
    check("R8 addr3 ignored", periphRstOut, PMASK);
    check("R8 addr3 status", statusOut, 32'h83);
    doWrite(2'd2, 32'h0);
    check("R8 cleared", periphRstOut, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule